// File: doc/BRIEF.md
# Serial Flash Array Read Sequencer

This block is the read-side front end of a serial flash device. It acts as an SPI slave: after chip select falls it collects an 8-bit command, a 24-bit address and a 32-bit dummy field, then streams array bytes out on the serial output, most significant bit first, for as long as the master keeps toggling SCK. Two read commands are understood. The page read stays within the 264-byte page it started in. The continuous read walks forward through the whole 2048-page array without needing a new address.

The array itself lives outside the block. The sequencer presents a linear byte address (page times 264 plus byte) together with a one-cycle read strobe, and the memory returns the byte on the next system clock. Pin signals (chip select, SCK, SI) are brought onto the system clock through a synchronizer, so SCK must run well below the system clock: each SCK high and low phase has to last at least four system clock cycles. SO is meant to drive a tri-state pad whose enable is the separate `so_oe` output.

Top module: `sflash_read_seq`

## Requirements
- R1: Command bytes 0x68 and 0xE8 start a continuous read; 0x52 and 0xD2 start a page read. Any other command byte leaves `so_oe` low until chip select is released.
- R2: Bits on SI are taken on rising SCK, MSB first: 8 command bits, then 24 address bits, then 32 ignored dummy bits. `so_oe` stays low through all 64 of these; the MSB of the first data byte is driven after the falling SCK that follows the 64th rising edge.
- R3: Of the 24 address bits (sent MSB first), bits 23..20 are ignored, bits 19..9 select the page and bits 8..0 the starting byte; the array is addressed at `mem_addr` = page*264 + byte.
- R4: A starting byte field of 264 to 511 is treated as byte 0 of the selected page.
- R5: In a page read, the byte after byte 263 is byte 0 of the same page.
- R6: In a continuous read, the byte after byte 263 is byte 0 of the next page, and page 2047 byte 263 is followed by page 0 byte 0.
- R7: Raising `cs_n` drops `so_oe` in the same instant; the next selection starts afresh with a command byte.
- R8: Data bits change on falling SCK, bytes follow each other with no gap bits, and every byte is fetched from the array before its first bit is due.
- R9: During and right after synchronous reset, `so_oe` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select from the master, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for the SO pad, high drives |
| mem_addr | output | 20 | Linear byte address into the array |
| mem_rd_en | output | 1 | One-cycle array read strobe |
| mem_rd_data | input | 8 | Array byte, valid the cycle after the strobe |

## Verification
A new SO bit appears within three system clock edges of a falling SCK at the pin (two synchronizer stages, then the shift register), and the next array byte is in the prefetch register four cycles after the previous byte was loaded; the bench therefore holds each SCK phase for six cycles and samples SO at the end of the low phase, just before the rising edge the master would use. The `so_oe` drop on deselect is combinational from `cs_n`, so it is checked one half cycle after the pin rises. Expected bytes come from a bench-side copy of the array contents and a bench-side model of the page and byte stepping rules.

// File: rtl/sfr_pkg.sv
// Package: shared types and command codes for the serial flash read sequencer.
// Assumes: command bytes are 8 bits and are compared as whole bytes.
package sfr_pkg;

    // Protocol phase of the current selection
    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_SKIP   = 3'd4
    } phase_e;

    // How the byte pointer moves past the end of a page
    typedef enum logic {
        RD_PAGE = 1'b0,
        RD_CONT = 1'b1
    } rdmode_e;

    localparam logic [7:0] CMD_CONT_LEGACY = 8'h68;
    localparam logic [7:0] CMD_CONT        = 8'hE8;
    localparam logic [7:0] CMD_PAGE_LEGACY = 8'h52;
    localparam logic [7:0] CMD_PAGE        = 8'hD2;

    function automatic logic cmd_is_cont(input logic [7:0] c);
        return (c == CMD_CONT_LEGACY) || (c == CMD_CONT);
    endfunction

    function automatic logic cmd_is_page(input logic [7:0] c);
        return (c == CMD_PAGE_LEGACY) || (c == CMD_PAGE);
    endfunction

endpackage

// File: rtl/sfr_pin_sync.sv
// Module: brings chip select, SCK and SI onto the system clock and finds SCK edges.
// Assumes: each SCK phase lasts at least STAGES+2 system clocks; edges are
// reported only while the synchronized chip select is active.
module sfr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    // pipe bit 2 = cs_n, bit 1 = sck, bit 0 = si
    logic [2:0] pipe_q [STAGES];
    logic       sck_prev_q;

    // First synchronizer stage takes the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= 3'b100;
        else        pipe_q[0] <= {cs_n, sck, si};
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Further synchronizer stages
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 3'b100;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    endgenerate

    // Remember the last synchronized SCK level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= pipe_q[STAGES-1][1];
    end

    assign sel      = ~pipe_q[STAGES-1][2];
    assign si_s     = pipe_q[STAGES-1][0];
    assign sck_rise = sel &  pipe_q[STAGES-1][1] & ~sck_prev_q;
    assign sck_fall = sel & ~pipe_q[STAGES-1][1] &  sck_prev_q;

endmodule

// File: rtl/sfr_cmd_decoder.sv
// Module: counts rising SCK bits through command, address and dummy phases,
// decodes the command and hands the page and raw byte field to the pointer.
// Assumes: only the low PAGE_AW+BYTE_AW address bits matter; the reserved
// upper bits fall off the top of the shift register.
module sfr_cmd_decoder
    import sfr_pkg::*;
#(
    parameter int PAGE_AW    = 11,
    parameter int BYTE_AW    = 9,
    parameter int RSV_W      = 4,
    parameter int DUMMY_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               sck_rise,
    input  logic               si_s,
    output phase_e             phase,
    output rdmode_e            mode,
    output logic               addr_load,
    output logic [PAGE_AW-1:0] load_page,
    output logic [BYTE_AW-1:0] load_byte
);
    localparam int OP_BITS   = 8;
    localparam int FIELD_W   = PAGE_AW + BYTE_AW;
    localparam int ADDR_BITS = RSV_W + FIELD_W;
    localparam int MAX_CNT   = (DUMMY_BITS > ADDR_BITS) ? DUMMY_BITS : ADDR_BITS;
    localparam int CNT_W     = $clog2(MAX_CNT);

    phase_e             phase_q;
    rdmode_e            mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIELD_W-1:0] sh_q;
    logic [FIELD_W-1:0] sh_next;
    logic [OP_BITS-1:0] cmd_next;
    logic               load_q;
    logic [PAGE_AW-1:0] page_q;
    logic [BYTE_AW-1:0] byte_q;

    assign sh_next  = {sh_q[FIELD_W-2:0], si_s};
    assign cmd_next = sh_next[OP_BITS-1:0];

    // Phase sequencing on each rising SCK; deselect restarts at the command
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase_q <= PH_OPCODE;
            mode_q  <= RD_PAGE;
            cnt_q   <= '0;
            sh_q    <= '0;
            load_q  <= 1'b0;
            page_q  <= '0;
            byte_q  <= '0;
        end else begin
            load_q <= 1'b0;
            if (sck_rise) begin
                sh_q <= sh_next;
                unique case (phase_q)
                    PH_OPCODE: begin
                        if (cnt_q == CNT_W'(OP_BITS - 1)) begin
                            cnt_q <= '0;
                            if (cmd_is_cont(cmd_next)) begin
                                phase_q <= PH_ADDR;
                                mode_q  <= RD_CONT;
                            end else if (cmd_is_page(cmd_next)) begin
                                phase_q <= PH_ADDR;
                                mode_q  <= RD_PAGE;
                            end else begin
                                phase_q <= PH_SKIP;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DUMMY;
                            load_q  <= 1'b1;
                            page_q  <= sh_next[FIELD_W-1:BYTE_AW];
                            byte_q  <= sh_next[BYTE_AW-1:0];
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt_q == CNT_W'(DUMMY_BITS - 1)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase     = phase_q;
    assign mode      = mode_q;
    assign addr_load = load_q;
    assign load_page = page_q;
    assign load_byte = byte_q;

    // An unknown command holds the skip phase for the rest of the selection
    p_skip_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP && sel) |=> (phase_q == PH_SKIP || !sel));

    // Data never begins before the address has been handed over
    p_load_before_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DUMMY) |-> !(load_q && sck_rise && cnt_q == CNT_W'(DUMMY_BITS - 1)));

endmodule

// File: rtl/sfr_addr_gen.sv
// Module: page and byte pointer, linear address, array read strobe and the
// one-byte prefetch register.
// Assumes: the array returns data on the cycle after mem_rd_en; load and
// advance never come on the same cycle.
module sfr_addr_gen
    import sfr_pkg::*;
#(
    parameter int PAGE_BYTES = 264,
    parameter int NUM_PAGES  = 2048,
    parameter int PAGE_AW    = 11,
    parameter int BYTE_AW    = 9,
    parameter int LIN_AW     = 20,
    parameter int DATA_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAGE_AW-1:0] load_page,
    input  logic [BYTE_AW-1:0] load_byte,
    input  rdmode_e            mode,
    input  logic               adv,
    output logic [LIN_AW-1:0]  mem_addr,
    output logic               mem_rd_en,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic [DATA_W-1:0]  pf_byte,
    output logic               pf_valid
);
    localparam logic [BYTE_AW-1:0] LAST_BYTE = BYTE_AW'(PAGE_BYTES - 1);
    localparam logic [PAGE_AW-1:0] LAST_PAGE = PAGE_AW'(NUM_PAGES - 1);

    logic [PAGE_AW-1:0] page_q;
    logic [BYTE_AW-1:0] byte_q;
    logic               rd_q;
    logic               cap_q;
    logic [DATA_W-1:0]  pf_q;
    logic               pfv_q;

    // Pointer update on load or advance, and prefetch capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            byte_q <= '0;
            rd_q   <= 1'b0;
            cap_q  <= 1'b0;
            pf_q   <= '0;
            pfv_q  <= 1'b0;
        end else begin
            rd_q  <= 1'b0;
            cap_q <= rd_q;
            if (cap_q) begin
                pf_q  <= mem_rd_data;
                pfv_q <= 1'b1;
            end
            if (load) begin
                page_q <= load_page;
                byte_q <= (32'(load_byte) >= PAGE_BYTES) ? '0 : load_byte;
                rd_q   <= 1'b1;
                pfv_q  <= 1'b0;
            end else if (adv) begin
                if (byte_q == LAST_BYTE) begin
                    byte_q <= '0;
                    if (mode == RD_CONT)
                        page_q <= (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
                end else begin
                    byte_q <= byte_q + 1'b1;
                end
                rd_q  <= 1'b1;
                pfv_q <= 1'b0;
            end
        end
    end

    assign mem_addr  = LIN_AW'(page_q) * LIN_AW'(PAGE_BYTES) + LIN_AW'(byte_q);
    assign mem_rd_en = rd_q;
    assign pf_byte   = pf_q;
    assign pf_valid  = pfv_q;

    // Byte pointer never leaves the page, even after an oversized start field
    p_byte_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= LAST_BYTE);

    // Page read wraps within the page
    p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == RD_PAGE && byte_q == LAST_BYTE)
            |=> (byte_q == '0 && $stable(page_q)));

    // Continuous read moves on to the following page, and off the last one to page 0
    p_cont_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == RD_CONT && byte_q == LAST_BYTE)
            |=> (byte_q == '0 &&
                 page_q == (($past(page_q) == LAST_PAGE) ? '0 : $past(page_q) + 1'b1)));

    // Reset leaves the array port idle
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !mem_rd_en);

endmodule

// File: rtl/sfr_out_shift.sv
// Module: serial output shift register; loads a prefetched byte every DATA_W
// falling SCK edges and asks the pointer to step.
// Assumes: the prefetch register is filled before its byte is due.
module sfr_out_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck_fall,
    input  logic              data_phase,
    input  logic [DATA_W-1:0] pf_byte,
    input  logic              pf_valid,
    output logic              so_bit,
    output logic              active,
    output logic              adv
);
    localparam int BP_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [BP_W-1:0]   bp_q;
    logic              act_q;
    logic              adv_q;

    // Shift or reload on each falling SCK of the data phase
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            sh_q  <= '0;
            bp_q  <= '0;
            act_q <= 1'b0;
            adv_q <= 1'b0;
        end else begin
            adv_q <= 1'b0;
            if (sck_fall && data_phase) begin
                if (bp_q == '0) begin
                    sh_q  <= pf_byte;
                    adv_q <= 1'b1;
                    act_q <= 1'b1;
                end else begin
                    sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                end
                bp_q <= (bp_q == BP_W'(DATA_W - 1)) ? '0 : bp_q + 1'b1;
            end
        end
    end

    assign so_bit = sh_q[DATA_W-1];
    assign active = act_q;
    assign adv    = adv_q;

    // The next byte is ready whenever a byte boundary falls
    p_prefetch_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && sck_fall && data_phase && bp_q == '0) |-> pf_valid);

endmodule

// File: rtl/sflash_read_seq.sv
// Module: top of the serial flash array read sequencer. Ties the pin
// synchronizer, command decoder, address pointer and output shifter together.
// Assumes: SCK phases of at least four clk cycles; array read latency of one
// cycle; SO is tri-stated outside the pad by so_oe.
module sflash_read_seq
    import sfr_pkg::*;
#(
    parameter int PAGE_BYTES  = 264,
    parameter int NUM_PAGES   = 2048,
    parameter int RSV_W       = 4,
    parameter int DUMMY_BITS  = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int PAGE_AW     = $clog2(NUM_PAGES),
    parameter int BYTE_AW     = $clog2(PAGE_BYTES),
    parameter int LIN_AW      = $clog2(PAGE_BYTES * NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic [LIN_AW-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic               sel, sck_rise, sck_fall, si_s;
    phase_e             phase;
    rdmode_e            mode;
    logic               addr_load;
    logic [PAGE_AW-1:0] load_page;
    logic [BYTE_AW-1:0] load_byte;
    logic [DATA_W-1:0]  pf_byte;
    logic               pf_valid;
    logic               so_bit, active, adv;

    sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    sfr_cmd_decoder #(
        .PAGE_AW    (PAGE_AW),
        .BYTE_AW    (BYTE_AW),
        .RSV_W      (RSV_W),
        .DUMMY_BITS (DUMMY_BITS)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sck_rise  (sck_rise),
        .si_s      (si_s),
        .phase     (phase),
        .mode      (mode),
        .addr_load (addr_load),
        .load_page (load_page),
        .load_byte (load_byte)
    );

    sfr_addr_gen #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_AW    (PAGE_AW),
        .BYTE_AW    (BYTE_AW),
        .LIN_AW     (LIN_AW),
        .DATA_W     (DATA_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (addr_load),
        .load_page   (load_page),
        .load_byte   (load_byte),
        .mode        (mode),
        .adv         (adv),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_data (mem_rd_data),
        .pf_byte     (pf_byte),
        .pf_valid    (pf_valid)
    );

    sfr_out_shift #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sck_fall   (sck_fall),
        .data_phase (phase == PH_DATA),
        .pf_byte    (pf_byte),
        .pf_valid   (pf_valid),
        .so_bit     (so_bit),
        .active     (active),
        .adv        (adv)
    );

    assign so    = so_bit;
    assign so_oe = active & ~cs_n;

    // SO is only ever driven in the data phase
    p_oe_only_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (phase == PH_DATA));

    // A fresh selection starts with the output released
    p_fresh_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> !so_oe);

    // Reset leaves the pad released
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !so_oe);

endmodule

// File: tb/sim_sflash_read_seq.sv
module sim_sflash_read_seq;
    localparam int HALF = 6;
    localparam int PB   = 264;
    localparam int NP   = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic [19:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_data = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sflash_read_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .si          (si),
        .so          (so),
        .so_oe       (so_oe),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ {a[19:16], a[19:16]} ^ 8'hA5;
    endfunction

    // Array model: one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic last_oe;

    task automatic xfer(input logic b, output logic o);
        si = b;
        repeat (HALF) @(negedge clk);
        o = so;
        last_oe = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    // Select, send command, address and dummy; oe must stay low (R2)
    task automatic send_cmd(input logic [7:0] op, input logic [23:0] adr);
        logic o;
        logic oe_seen = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin xfer(op[i], o); oe_seen |= last_oe; end
        for (int i = 23; i >= 0; i--) begin xfer(adr[i], o); oe_seen |= last_oe; end
        for (int i = 0; i < 32; i++) begin xfer(1'b0, o); oe_seen |= last_oe; end
        check("R2 oe low during header", 32'(oe_seen), 32'd0);
    endtask

    task automatic read_byte(output logic [7:0] d, output logic oe_all);
        logic o;
        oe_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, o);
            d = {d[6:0], o};
            oe_all &= last_oe;
        end
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // op, reserved, page, byte, count
    localparam logic [39:0] VEC [8] = '{
        {8'h68, 4'h0, 11'd0,    9'd0,   8'd4},  // R1 continuous basic
        {8'hE8, 4'hF, 11'd100,  9'd5,   8'd3},  // R3 reserved bits ignored
        {8'h52, 4'h0, 11'd7,    9'd260, 8'd6},  // R5 page wrap
        {8'hD2, 4'hA, 11'd2047, 9'd263, 8'd2},  // R5 page wrap, last page
        {8'h68, 4'h0, 11'd12,   9'd262, 8'd4},  // R6 next page
        {8'hE8, 4'h0, 11'd2047, 9'd262, 8'd3},  // R6 end of array
        {8'h52, 4'h0, 11'd33,   9'd300, 8'd3},  // R4 clamp in page read
        {8'h68, 4'h0, 11'd9,    9'd511, 8'd2}   // R4 clamp in continuous read
    };

    initial begin
        logic [7:0] d;
        logic       oe_all;
        logic       o;
        repeat (3) @(negedge clk);
        check("R9 reset so_oe", 32'(so_oe), 32'd0);
        check("R9 reset mem_rd_en", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 after reset so_oe", 32'(so_oe), 32'd0);

        // Table-driven reads (R1 R3 R4 R5 R6 R8)
        for (int v = 0; v < 8; v++) begin
            logic [7:0]  op;
            logic [3:0]  rsv;
            logic [10:0] pg;
            logic [8:0]  by;
            logic [7:0]  n;
            int          p, b;
            bit          cont;
            {op, rsv, pg, by, n} = VEC[v];
            cont = (op == 8'h68) || (op == 8'hE8);
            p = int'(pg);
            b = (int'(by) >= PB) ? 0 : int'(by);
            send_cmd(op, {rsv, pg, by});
            for (int k = 0; k < int'(n); k++) begin
                read_byte(d, oe_all);
                check($sformatf("R8 vec%0d byte%0d (R3/R4/R5/R6)", v, k),
                      32'(d), 32'(mem_byte(20'(p * PB + b))));
                check("R2 oe high in data", 32'(oe_all), 32'd1);
                b++;
                if (b == PB) begin
                    b = 0;
                    if (cont) p = (p + 1) % NP;
                end
            end
            deselect();
        end

        // R1: unknown command keeps SO released
        send_cmd(8'h57, 24'h000010);
        for (int i = 0; i < 16; i++) xfer(1'b0, o);
        check("R1 unknown command oe", 32'(last_oe), 32'd0);
        deselect();

        // R7: abort mid-byte, oe drops with cs_n, then a fresh command works
        send_cmd(8'hE8, {4'h0, 11'd50, 9'd20});
        read_byte(d, oe_all);
        for (int i = 0; i < 4; i++) xfer(1'b0, o);
        check("R7 oe high before release", 32'(so_oe), 32'd1);
        cs_n = 1'b1;
        @(posedge clk);
        check("R7 oe drop on cs rise", 32'(so_oe), 32'd0);
        repeat (2 * HALF) @(negedge clk);
        send_cmd(8'h52, {4'h0, 11'd3, 9'd10});
        read_byte(d, oe_all);
        check("R7 fresh command after abort", 32'(d), 32'(mem_byte(20'(3 * PB + 10))));
        deselect();

        // R8: first data bit is the MSB, visible right after the header
        send_cmd(8'h68, {4'h0, 11'd1, 9'd1});
        xfer(1'b0, o);
        check("R8 first bit is MSB", 32'(o), 32'(mem_byte(20'(PB + 1)) >> 7));
        deselect();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule